// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates six interrupt sources for a small processor core: external line 0, timer 0, external line 1, timer 1, the serial port and timer 2. Peripherals present their raw pending flags. The block masks them with a software-written enable register that has a master switch, and sorts them into a high or a low level with a priority register. It then raises one request toward the core, together with the fixed program address of the winning source.

Two in-service flags record which levels are being handled. A high-level source can interrupt a low-level handler. A low-level source cannot interrupt anything, and no source can interrupt a handler of its own level. The core pulses an acknowledge input when it takes the vector, and a return input when a handler finishes. Detecting edges on the external pins and clearing peripheral flags are done elsewhere.

The raw flag input `flags_in` is packed as follows:

| Bit | Flag |
|-----|------|
| 0 | external 0 |
| 1 | timer 0 |
| 2 | external 1 |
| 3 | timer 1 |
| 4 | serial receive |
| 5 | serial transmit |
| 6 | timer-2 overflow |
| 7 | timer-2 external |

Top module: `vic_top`

## Requirements
- R1: After reset, both registers read 0x00, `irq_req` is 0, `irq_vec` is 0x0000 and `in_svc` is 2'b00.
- R2: Writing the enable register stores the data with bit 6 forced to 0. The bit positions are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 7 master. A pending source whose enable bit is 0 never produces a request.
- R3: While enable bit 7 is 0, `irq_req` stays 0 whatever the other bits and flags are.
- R4: Writing the priority register stores the data with bits 7 and 6 forced to 0. The bit positions are the same as in the enable register, and a 1 places the source on the high level.
- R5: The vector equals 0x0003 + 8 × index, where the index is 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1, 4 for serial and 5 for timer 2. The vector is 0x0000 when there is no request.
- R6: The serial source is pending if `flags_in[4]` or `flags_in[5]` is 1. The timer-2 source is pending if `flags_in[6]` or `flags_in[7]` is 1.
- R7: Among eligible sources on the same level, the lowest index wins.
- R8: An eligible high-level source wins over low-level sources. It is requested while only the low level is in service.
- R9: A low-level source is requested only when no level is in service. A high-level source is not requested while the high level is in service.
- R10: `irq_ack` while `irq_req` is 1 sets the in-service flag of the requested level. `irq_reti` clears the high flag if it is set, and otherwise clears the low flag. A return takes effect before an acknowledge in the same cycle.
- R11: `irq_req` and `irq_vec` are registered. They reflect the flags, the register contents and the in-service state one clock edge after those settle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena_wr | input | 1 | Write strobe for the enable register |
| pri_wr | input | 1 | Write strobe for the priority register |
| wr_data | input | 8 | Register write data |
| flags_in | input | 8 | Raw peripheral pending flags |
| irq_ack | input | 1 | Core has taken the presented vector |
| irq_reti | input | 1 | Core has returned from a handler |
| ena_rd | output | 8 | Enable register contents |
| pri_rd | output | 8 | Priority register contents |
| irq_req | output | 1 | Interrupt request to the core |
| irq_lvl | output | 1 | Level of the request, 1 for high |
| irq_vec | output | 16 | Program address of the winning source |
| in_svc | output | 2 | In-service flags, {high, low} |

## Verification
Each source is first raised alone. This separates the six vector values and shows that either flag of the serial and timer-2 sources is enough. Sets of several simultaneous flags on one level tell the fixed order apart from any other order. Mixed-level sets with acknowledges and returns in between show preemption by the high level, blocking of the low level, and which flag each return clears. A long stretch of random flags, register writes, acknowledges and returns is compared every cycle with a behavioural model, so that rare combinations of writes and service state are covered.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC    = 6;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int REG_W   = 8;
    localparam int VEC_W   = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int MASTER_BIT = 7;
    localparam logic [REG_W-1:0] ENA_MASK = 8'hBF;
    localparam logic [REG_W-1:0] PRI_MASK = 8'h3F;

    typedef enum logic { LVL_LO = 1'b0, LVL_HI = 1'b1 } lvl_e;

    typedef struct packed {
        logic [REG_W-1:0] ena;
        logic [REG_W-1:0] pri;
        logic [1:0]       svc;
        logic             req;
        lvl_e             lvl;
        logic [VEC_W-1:0] vec;
    } vic_state_t;
endpackage

// File: rtl/vic_src_merge.sv
module vic_src_merge
    import vic_pkg::*;
(
    input  logic [7:0]       flags_in,
    input  logic [REG_W-1:0] ena,
    input  logic [REG_W-1:0] pri,
    output logic [NSRC-1:0]  hi_cand,
    output logic [NSRC-1:0]  lo_cand
);
    logic [NSRC-1:0] raw_pend;
    logic [NSRC-1:0] live;

    always_comb begin
        raw_pend[0] = flags_in[0];
        raw_pend[1] = flags_in[1];
        raw_pend[2] = flags_in[2];
        raw_pend[3] = flags_in[3];
        raw_pend[4] = flags_in[4] | flags_in[5];
        raw_pend[5] = flags_in[6] | flags_in[7];
        live    = raw_pend & ena[NSRC-1:0] & {NSRC{ena[MASTER_BIT]}};
        hi_cand = live & pri[NSRC-1:0];
        lo_cand = live & ~pri[NSRC-1:0];
    end
endmodule

// File: rtl/vic_pick.sv
module vic_pick
    import vic_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R7: the chosen candidate is set and no lower-index candidate is set
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (cand[idx] && ((cand & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/vic_svc_next.sv
module vic_svc_next
    import vic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] svc_q,
    input  logic       reti,
    input  logic       take,
    input  lvl_e       take_lvl,
    output logic [1:0] svc_d
);
    logic [1:0] after_ret;

    always_comb begin
        after_ret = svc_q;
        if (reti) begin
            if (svc_q[1]) after_ret[1] = 1'b0;
            else          after_ret[0] = 1'b0;
        end
        svc_d = after_ret;
        if (take) svc_d[take_lvl] = 1'b1;
    end

    // R10: a return with high in service drops it unless a high vector is taken
    a_r10_ret_high: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && svc_q[1] && !(take && take_lvl == LVL_HI)) |-> !svc_d[1]);
    // R10: a return with only low in service drops low unless a low vector is taken
    a_r10_ret_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !svc_q[1] && !(take && take_lvl == LVL_LO)) |-> !svc_d[0]);
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_wr,
    input  logic             pri_wr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       flags_in,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic [7:0]       ena_rd,
    output logic [7:0]       pri_rd,
    output logic             irq_req,
    output logic             irq_lvl,
    output logic [VEC_W-1:0] irq_vec,
    output logic [1:0]       in_svc
);
    vic_state_t st_q, st_d;

    logic [NSRC-1:0]  hi_cand, lo_cand;
    logic [NSRC-1:0]  cand [2];
    logic [1:0]       lvl_found;
    logic [IDX_W-1:0] lvl_idx [2];
    logic [1:0]       svc_d;
    logic             hi_ok, lo_ok;
    logic [IDX_W-1:0] win_idx;

    vic_src_merge u_merge (
        .flags_in (flags_in),
        .ena      (st_q.ena),
        .pri      (st_q.pri),
        .hi_cand  (hi_cand),
        .lo_cand  (lo_cand)
    );

    assign cand[LVL_LO] = lo_cand;
    assign cand[LVL_HI] = hi_cand;

    for (genvar g = 0; g < 2; g++) begin : g_level
        vic_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .cand  (cand[g]),
            .found (lvl_found[g]),
            .idx   (lvl_idx[g])
        );
    end

    vic_svc_next u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_q    (st_q.svc),
        .reti     (irq_reti),
        .take     (irq_ack && st_q.req),
        .take_lvl (st_q.lvl),
        .svc_d    (svc_d)
    );

    always_comb begin
        st_d = st_q;
        if (ena_wr) st_d.ena = wr_data & ENA_MASK;
        if (pri_wr) st_d.pri = wr_data & PRI_MASK;
        st_d.svc = svc_d;
        hi_ok    = lvl_found[LVL_HI] && !svc_d[1];
        lo_ok    = lvl_found[LVL_LO] && (svc_d == 2'b00);
        win_idx  = hi_ok ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
        st_d.req = hi_ok || lo_ok;
        st_d.lvl = hi_ok ? LVL_HI : LVL_LO;
        st_d.vec = (hi_ok || lo_ok)
                 ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP)
                 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_rd  = st_q.ena;
    assign pri_rd  = st_q.pri;
    assign irq_req = st_q.req;
    assign irq_lvl = st_q.lvl;
    assign irq_vec = st_q.vec;
    assign in_svc  = st_q.svc;

    // R3: master switch off means no request on the following cycle
    a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_rd[MASTER_BIT] |=> !irq_req);
    // R2 and R4: unused register bits never hold a 1
    a_r2_r4_unused_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_rd[6] && (pri_rd[7:6] == 2'b00));
    // R5: a presented vector lies on the 8-byte grid starting at 0x0003
    a_r5_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h002B));
    // R9: a low-level request only while nothing is in service
    a_r9_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_lvl) |-> (in_svc == 2'b00));
    // R8: a high-level request only while high is not in service
    a_r8_high_free: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_lvl) |-> !in_svc[1]);
    // R10: taking a request marks its level in service
    a_r10_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> in_svc[$past(irq_lvl)]);
endmodule

// File: tb/vic_top_test.sv
module vic_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ena_wr = 1'b0, pri_wr = 1'b0;
    logic [7:0]  wr_data = '0, flags_in = '0;
    logic        irq_ack = 1'b0, irq_reti = 1'b0;
    logic [7:0]  ena_rd, pri_rd;
    logic        irq_req, irq_lvl;
    logic [15:0] irq_vec;
    logic [1:0]  in_svc;

    int checks = 0, errors = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    vic_top uut (
        .clk(clk), .rst_n(rst_n), .ena_wr(ena_wr), .pri_wr(pri_wr),
        .wr_data(wr_data), .flags_in(flags_in), .irq_ack(irq_ack),
        .irq_reti(irq_reti), .ena_rd(ena_rd), .pri_rd(pri_rd),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec), .in_svc(in_svc)
    );

    // behavioural reference model
    int m_ena = 0, m_pri = 0, m_hi = 0, m_lo = 0, m_req = 0, m_lvl = 0, m_vec = 0;
    int pend[6];
    int win, wlvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ena = 0; m_pri = 0; m_hi = 0; m_lo = 0; m_req = 0; m_lvl = 0; m_vec = 0;
        end else begin
            pend[0] = flags_in[0]; pend[1] = flags_in[1];
            pend[2] = flags_in[2]; pend[3] = flags_in[3];
            pend[4] = (flags_in[4] || flags_in[5]) ? 1 : 0;
            pend[5] = (flags_in[6] || flags_in[7]) ? 1 : 0;
            if (irq_reti) begin
                if (m_hi != 0) m_hi = 0; else m_lo = 0;
            end
            if (irq_ack && m_req != 0) begin
                if (m_lvl != 0) m_hi = 1; else m_lo = 1;
            end
            win = -1; wlvl = 0;
            if (((m_ena >> 7) & 1) != 0) begin
                if (m_hi == 0)
                    for (int s = 5; s >= 0; s--)
                        if (pend[s] != 0 && ((m_ena >> s) & 1) != 0 && ((m_pri >> s) & 1) != 0) begin
                            win = s; wlvl = 1;
                        end
                if (win < 0 && m_hi == 0 && m_lo == 0)
                    for (int s = 5; s >= 0; s--)
                        if (pend[s] != 0 && ((m_ena >> s) & 1) != 0 && ((m_pri >> s) & 1) == 0)
                            win = s;
            end
            m_req = (win >= 0) ? 1 : 0;
            m_lvl = wlvl;
            m_vec = (win >= 0) ? 3 + 8 * win : 0;
            if (ena_wr) m_ena = wr_data & 8'hBF;
            if (pri_wr) m_pri = wr_data & 8'h3F;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " model req"}, irq_req, m_req);
            chk({phase, " model vec"}, irq_vec, m_vec);
            if (m_req != 0) chk({phase, " model lvl"}, irq_lvl, m_lvl);
            chk({phase, " model svc"}, in_svc, m_hi * 2 + m_lo);
            chk({phase, " model ena"}, ena_rd, m_ena);
            chk({phase, " model pri"}, pri_rd, m_pri);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ena(logic [7:0] v);
        wr_data = v; ena_wr = 1'b1; tick(); ena_wr = 1'b0;
    endtask

    task automatic wr_pri(logic [7:0] v);
        wr_data = v; pri_wr = 1'b1; tick(); pri_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        irq_reti = 1'b1; tick(); irq_reti = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        phase = "R1";
        chk("R1 ena reset", ena_rd, 8'h00);
        chk("R1 pri reset", pri_rd, 8'h00);
        chk("R1 req reset", irq_req, 0);
        chk("R1 vec reset", irq_vec, 16'h0000);
        chk("R1 svc reset", in_svc, 2'b00);
        rst_n = 1'b1;
        tick();

        phase = "R2";
        wr_ena(8'hFF);
        chk("R2 bit6 dropped", ena_rd, 8'hBF);
        phase = "R4";
        wr_pri(8'hFF);
        chk("R4 bits7-6 dropped", pri_rd, 8'h3F);
        wr_pri(8'h00);

        phase = "R3";
        wr_ena(8'h3F);
        flags_in = 8'hFF; tick(3);
        chk("R3 master off no req", irq_req, 0);
        flags_in = 8'h00; tick();

        phase = "R5";
        wr_ena(8'hBF);
        for (int s = 0; s < 6; s++) begin
            flags_in = 8'h00;
            case (s)
                4: flags_in[4] = 1'b1;
                5: flags_in[6] = 1'b1;
                default: flags_in[s] = 1'b1;
            endcase
            tick();
            chk("R5 vector", irq_vec, 3 + 8 * s);
        end

        phase = "R6";
        flags_in = 8'h20; tick();
        chk("R6 serial tx alone", irq_vec, 16'h0023);
        flags_in = 8'h80; tick();
        chk("R6 timer2 ext alone", irq_vec, 16'h002B);

        phase = "R11";
        flags_in = 8'h00; tick();
        flags_in = 8'h04; #1;
        chk("R11 not yet", irq_req, 0);
        tick();
        chk("R11 one edge later", irq_vec, 16'h0013);

        phase = "R2";
        flags_in = 8'h04;
        wr_ena(8'hBB);
        tick();
        chk("R2 disabled source", irq_req, 0);
        wr_ena(8'hBF);

        phase = "R7";
        flags_in = 8'hFE; tick();
        chk("R7 timer0 first", irq_vec, 16'h000B);
        flags_in = 8'hF8; tick();
        chk("R7 timer1 first", irq_vec, 16'h001B);
        flags_in = 8'hFF; tick();
        chk("R7 ext0 first", irq_vec, 16'h0003);

        phase = "R8";
        wr_pri(8'h20);
        tick();
        chk("R8 high beats low", irq_vec, 16'h002B);
        chk("R8 level high", irq_lvl, 1);

        phase = "R10";
        wr_pri(8'h00);
        flags_in = 8'h01; tick();
        pulse_ack();
        chk("R10 low in service", in_svc, 2'b01);
        phase = "R9";
        flags_in = 8'h09; tick(2);
        chk("R9 low blocked", irq_req, 0);
        phase = "R8";
        wr_pri(8'h08);
        tick();
        chk("R8 high preempts", irq_vec, 16'h001B);
        phase = "R10";
        pulse_ack();
        chk("R10 both in service", in_svc, 2'b11);
        phase = "R9";
        tick();
        chk("R9 same level blocked", irq_req, 0);
        phase = "R10";
        pulse_reti();
        chk("R10 reti clears high", in_svc, 2'b01);
        pulse_reti();
        chk("R10 reti clears low", in_svc, 2'b00);
        flags_in = 8'h00; tick(2);

        phase = "R9";
        for (int i = 0; i < 4000; i++) begin
            flags_in = 8'($urandom);
            ena_wr = ($urandom % 16) == 0;
            pri_wr = ($urandom % 16) == 0;
            wr_data = 8'($urandom) | 8'h80;
            irq_ack = irq_req && ($urandom % 3 == 0);
            irq_reti = ($urandom % 5) == 0;
            tick();
        end
        ena_wr = 1'b0; pri_wr = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
        tick(2);
        finish_run();
    end
endmodule